// File: doc/BRIEF.md
# Reset Cause Status Register

This block records why the processor last restarted or woke. It keeps seven status flags and, for each restart or wake event, works out the next program-counter value. Each flag has its own polarity. Some cause flags read 0 after their event and 1 otherwise, which lets software tell the causes apart after any restart.

The event inputs are single-cycle pulses. They cover brown-out, master clear, watchdog expiry, the reset instruction, stack overflow and underflow, and interrupt wake. The active-low `rstN` input is the power-on condition. Each event has its own set/clear pattern on the flags. A true reset raises `rstReq` and restarts at address 0. A wake from a power-managed mode does not reset. It resumes at the current program counter plus 2, or at an interrupt vector. Software can overwrite all flags through a write port.

Top module: `rst_cause_status`

## Requirements
- R1: While `rstN` is low (power-on), `flags` is 7'b0011100 and `rstReq`, `pcLoad` and `nextPc` are 0. Flag positions are: bit0 brown-out, bit1 power-on, bit2 power-down, bit3 watchdog, bit4 reset-instruction, bit5 stack underflow, bit6 stack overflow.
- R2: A reset instruction clears bit4 and leaves every other flag unchanged.
- R3: A brown-out clears bit0, sets bits 4, 3 and 2, and keeps bit1.
- R4: Master clear sets bit3. `pwrMode` is 0 for run, 1 for idle and 2 or 3 for sleep. In idle or sleep, master clear also clears bit2.
- R5: A watchdog expiry in run mode clears bit3 and is a true reset.
- R6: A watchdog expiry in idle or sleep clears bits 3 and 2. It is not a reset: `pcLoad` pulses and `nextPc` becomes `curPc`+2, wrapping at the counter width.
- R7: Stack overflow sets bit6 and stack underflow sets bit5. Either one is a true reset only when `stackRstEn` is 1. Otherwise only the flag changes.
- R8: An interrupt wake clears bit2 and raises `pcLoad` without a reset. `nextPc` is 0x08 if `intHigh` and `gieHigh` are both 1. It is 0x18 if `intHigh` is 0 and `gieLow` is 1. Otherwise it is `curPc`+2.
- R9: Every true reset gives a one-cycle pulse on both `rstReq` and `pcLoad`, with `nextPc` = 0. Outputs change at the clock edge that samples the event. `nextPc` holds its value when there is no load.
- R10: When events coincide, only one acts. The order, highest first, is brown-out, master clear, watchdog, reset instruction, stack, interrupt wake, software write.
- R11: A write with no event loads `flags` from `wrData`, which can set any flag again. A cycle with no event and no write changes no flag and raises neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| brownOut | input | 1 | Brown-out event pulse |
| mclr | input | 1 | Master clear event pulse |
| pwrMode | input | 2 | Power context: 0 run, 1 idle, 2/3 sleep |
| wdogExpire | input | 1 | Watchdog expiry pulse |
| resetInstr | input | 1 | Reset instruction executed |
| stackFull | input | 1 | Stack overflow event |
| stackUnder | input | 1 | Stack underflow event |
| stackRstEn | input | 1 | Stack errors cause a reset when 1 |
| intWake | input | 1 | Interrupt wake event |
| intHigh | input | 1 | Waking interrupt is high priority |
| gieHigh | input | 1 | High-priority global interrupt enable |
| gieLow | input | 1 | Low-priority global interrupt enable |
| curPc | input | PC_W | Current program counter |
| wrEn | input | 1 | Software flag write strobe |
| wrData | input | 7 | Software flag write value |
| flags | output | 7 | Status flags |
| rstReq | output | 1 | True-reset request pulse |
| pcLoad | output | 1 | Program-counter load pulse |
| nextPc | output | PC_W | Restart or resume address |

## Verification
The bench aims at the places where mode context changes the outcome. A watchdog expiry in sleep that was wrongly treated as a reset would pulse `rstReq` and load 0 instead of `curPc`+2. A master clear that ignored idle would leave the power-down flag set. The stack enable is run both ways: a design that always reset on underflow would pulse `rstReq` when the enable is 0. Coinciding events and a write during an event show whether a lower-priority cause leaks flag changes through. A resume from the top of the counter range checks the wrap. The brown-out case confirms that the power-on flag is kept rather than cleared.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int NFLAG    = 7;
  localparam int F_BROWN  = 0;
  localparam int F_PWRON  = 1;
  localparam int F_SLEEP  = 2;
  localparam int F_WDOG   = 3;
  localparam int F_SWRST  = 4;
  localparam int F_STKUND = 5;
  localparam int F_STKOVR = 6;
  localparam logic [NFLAG-1:0] PWRON_FLAGS = 7'b0011100;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_SLEEP = 2'd2,
    MODE_DEEP  = 2'd3
  } pwr_mode_e;

  typedef enum logic [1:0] {
    PC_ZERO   = 2'd0,
    PC_NEXT   = 2'd1,
    PC_VEC_HI = 2'd2,
    PC_VEC_LO = 2'd3
  } pc_sel_e;

  typedef struct packed {
    logic [NFLAG-1:0] setMask;
    logic [NFLAG-1:0] clrMask;
    logic             wrLoad;
    logic             rstHit;
    logic             resume;
    pc_sel_e          pcSel;
  } strobe_t;
endpackage

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
(
  input  logic       brownOut,
  input  logic       mclr,
  input  logic [1:0] pwrMode,
  input  logic       wdogExpire,
  input  logic       resetInstr,
  input  logic       stackFull,
  input  logic       stackUnder,
  input  logic       stackRstEn,
  input  logic       intWake,
  input  logic       intHigh,
  input  logic       gieHigh,
  input  logic       gieLow,
  input  logic       wrEn,
  output strobe_t    stb
);
  logic lowPower;
  assign lowPower = (pwr_mode_e'(pwrMode) != MODE_RUN);

  // Priority chain: only the highest pending cause produces strobes.
  always_comb begin
    stb = '0;
    stb.pcSel = PC_ZERO;
    if (brownOut) begin
      stb.clrMask[F_BROWN] = 1'b1;
      stb.setMask[F_SWRST] = 1'b1;
      stb.setMask[F_WDOG]  = 1'b1;
      stb.setMask[F_SLEEP] = 1'b1;
      stb.rstHit = 1'b1;
    end else if (mclr) begin
      stb.setMask[F_WDOG] = 1'b1;
      if (lowPower) stb.clrMask[F_SLEEP] = 1'b1;
      stb.rstHit = 1'b1;
    end else if (wdogExpire) begin
      stb.clrMask[F_WDOG] = 1'b1;
      if (lowPower) begin
        stb.clrMask[F_SLEEP] = 1'b1;
        stb.resume = 1'b1;
        stb.pcSel  = PC_NEXT;
      end else begin
        stb.rstHit = 1'b1;
      end
    end else if (resetInstr) begin
      stb.clrMask[F_SWRST] = 1'b1;
      stb.rstHit = 1'b1;
    end else if (stackFull || stackUnder) begin
      stb.setMask[F_STKOVR] = stackFull;
      stb.setMask[F_STKUND] = stackUnder;
      stb.rstHit = stackRstEn;
    end else if (intWake) begin
      stb.clrMask[F_SLEEP] = 1'b1;
      stb.resume = 1'b1;
      if (intHigh && gieHigh)       stb.pcSel = PC_VEC_HI;
      else if (!intHigh && gieLow)  stb.pcSel = PC_VEC_LO;
      else                          stb.pcSel = PC_NEXT;
    end else if (wrEn) begin
      stb.wrLoad = 1'b1;
    end
  end
endmodule

// File: rtl/rcs_datapath.sv
module rcs_datapath
  import rcs_pkg::*;
#(
  parameter int PC_W    = 21,
  parameter int PC_STEP = 2,
  parameter int VEC_HI  = 8,
  parameter int VEC_LO  = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [PC_W-1:0]  curPc,
  input  logic [NFLAG-1:0] wrData,
  output logic [NFLAG-1:0] flags,
  output logic             rstReq,
  output logic             pcLoad,
  output logic [PC_W-1:0]  nextPc
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);
  localparam logic [PC_W-1:0] HI_V   = PC_W'(VEC_HI);
  localparam logic [PC_W-1:0] LO_V   = PC_W'(VEC_LO);

  logic [NFLAG-1:0] flagsQ;
  logic             rstReqQ, pcLoadQ;
  logic [PC_W-1:0]  nextPcQ, pcMux;

  always_comb begin
    unique case (stb.pcSel)
      PC_NEXT:   pcMux = curPc + STEP_V;
      PC_VEC_HI: pcMux = HI_V;
      PC_VEC_LO: pcMux = LO_V;
      default:   pcMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ  <= PWRON_FLAGS;
      rstReqQ <= 1'b0;
      pcLoadQ <= 1'b0;
      nextPcQ <= '0;
    end else begin
      if (stb.wrLoad) flagsQ <= wrData;
      else            flagsQ <= (flagsQ & ~stb.clrMask) | stb.setMask;
      rstReqQ <= stb.rstHit;
      pcLoadQ <= stb.rstHit | stb.resume;
      if (stb.rstHit || stb.resume) nextPcQ <= pcMux;
    end
  end

  assign flags  = flagsQ;
  assign rstReq = rstReqQ;
  assign pcLoad = pcLoadQ;
  assign nextPc = nextPcQ;
endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status #(
  parameter int PC_W    = 21,
  parameter int PC_STEP = 2,
  parameter int VEC_HI  = 8,
  parameter int VEC_LO  = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            brownOut,
  input  logic            mclr,
  input  logic [1:0]      pwrMode,
  input  logic            wdogExpire,
  input  logic            resetInstr,
  input  logic            stackFull,
  input  logic            stackUnder,
  input  logic            stackRstEn,
  input  logic            intWake,
  input  logic            intHigh,
  input  logic            gieHigh,
  input  logic            gieLow,
  input  logic [PC_W-1:0] curPc,
  input  logic            wrEn,
  input  logic [6:0]      wrData,
  output logic [6:0]      flags,
  output logic            rstReq,
  output logic            pcLoad,
  output logic [PC_W-1:0] nextPc
);
  rcs_pkg::strobe_t stb;

  rcs_ctrl uCtrl (
    .brownOut(brownOut), .mclr(mclr), .pwrMode(pwrMode),
    .wdogExpire(wdogExpire), .resetInstr(resetInstr),
    .stackFull(stackFull), .stackUnder(stackUnder), .stackRstEn(stackRstEn),
    .intWake(intWake), .intHigh(intHigh), .gieHigh(gieHigh), .gieLow(gieLow),
    .wrEn(wrEn), .stb(stb)
  );

  rcs_datapath #(.PC_W(PC_W), .PC_STEP(PC_STEP), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .curPc(curPc), .wrData(wrData),
    .flags(flags), .rstReq(rstReq), .pcLoad(pcLoad), .nextPc(nextPc)
  );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int PC_W    = 21,
  parameter int PC_STEP = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            brownOut,
  input logic            mclr,
  input logic [1:0]      pwrMode,
  input logic            wdogExpire,
  input logic            resetInstr,
  input logic            stackFull,
  input logic            stackUnder,
  input logic            stackRstEn,
  input logic            intWake,
  input logic            wrEn,
  input logic [PC_W-1:0] curPc,
  input logic [6:0]      flags,
  input logic            rstReq,
  input logic            pcLoad,
  input logic [PC_W-1:0] nextPc
);
  logic anyEvent;
  assign anyEvent = brownOut | mclr | wdogExpire | resetInstr | stackFull |
                    stackUnder | intWake | wrEn;

  // R3
  a_r3_brown_pattern: assert property (@(posedge clk) disable iff (!rstN)
    brownOut |=> (!flags[0] && flags[4] && flags[3] && flags[2] && rstReq));
  a_r3_keeps_pwron: assert property (@(posedge clk) disable iff (!rstN)
    brownOut |=> (flags[1] == $past(flags[1])));
  // R2
  a_r2_instr_clears: assert property (@(posedge clk) disable iff (!rstN)
    (resetInstr && !brownOut && !mclr && !wdogExpire) |=> (!flags[4] && rstReq));
  // R5
  a_r5_wdog_run: assert property (@(posedge clk) disable iff (!rstN)
    (wdogExpire && !brownOut && !mclr && pwrMode == 2'd0) |=> (!flags[3] && rstReq));
  // R6
  a_r6_wdog_resume: assert property (@(posedge clk) disable iff (!rstN)
    (wdogExpire && !brownOut && !mclr && pwrMode != 2'd0) |=>
      (!rstReq && pcLoad && nextPc == $past(curPc) + PC_W'(PC_STEP)));
  // R7
  a_r7_no_stack_reset: assert property (@(posedge clk) disable iff (!rstN)
    ((stackFull || stackUnder) && !stackRstEn && !brownOut && !mclr &&
     !wdogExpire && !resetInstr) |=> !rstReq);
  // R9
  a_r9_reset_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (pcLoad && nextPc == '0));
  // R11
  a_r11_quiet_hold: assert property (@(posedge clk) disable iff (!rstN)
    !anyEvent |=> (flags == $past(flags) && !pcLoad && !rstReq));
endmodule

bind rst_cause_status rcs_checker #(.PC_W(PC_W), .PC_STEP(PC_STEP)) uChk (
  .clk(clk), .rstN(rstN), .brownOut(brownOut), .mclr(mclr), .pwrMode(pwrMode),
  .wdogExpire(wdogExpire), .resetInstr(resetInstr), .stackFull(stackFull),
  .stackUnder(stackUnder), .stackRstEn(stackRstEn), .intWake(intWake),
  .wrEn(wrEn), .curPc(curPc), .flags(flags), .rstReq(rstReq),
  .pcLoad(pcLoad), .nextPc(nextPc)
);

// File: tb/tb_rst_cause_status.sv
module tb_rst_cause_status;
  localparam int PW = 21;

  logic clk = 1'b0;
  logic rstN;
  logic brownOut, mclr, wdogExpire, resetInstr, stackFull, stackUnder;
  logic stackRstEn, intWake, intHigh, gieHigh, gieLow, wrEn;
  logic [1:0] pwrMode;
  logic [PW-1:0] curPc;
  logic [6:0] wrData;
  logic [6:0] flags;
  logic rstReq, pcLoad;
  logic [PW-1:0] nextPc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [6:0] mFlags;
  logic mRst, mLoad;
  logic [PW-1:0] mPc;

  always #4 clk = ~clk;

  rst_cause_status #(.PC_W(PW)) dut (
    .clk(clk), .rstN(rstN), .brownOut(brownOut), .mclr(mclr), .pwrMode(pwrMode),
    .wdogExpire(wdogExpire), .resetInstr(resetInstr), .stackFull(stackFull),
    .stackUnder(stackUnder), .stackRstEn(stackRstEn), .intWake(intWake),
    .intHigh(intHigh), .gieHigh(gieHigh), .gieLow(gieLow), .curPc(curPc),
    .wrEn(wrEn), .wrData(wrData), .flags(flags), .rstReq(rstReq),
    .pcLoad(pcLoad), .nextPc(nextPc)
  );

  task automatic modelPowerOn();
    mFlags = 7'b0011100; mRst = 0; mLoad = 0; mPc = '0;
  endtask

  // behavioural model of one clock edge
  task automatic modelEdge();
    bit sleepCtx;
    sleepCtx = (pwrMode != 2'd0);
    mRst = 0; mLoad = 0;
    if (brownOut) begin
      mFlags[0] = 0; mFlags[2] = 1; mFlags[3] = 1; mFlags[4] = 1;
      mRst = 1; mLoad = 1; mPc = 0;
    end else if (mclr) begin
      mFlags[3] = 1;
      if (sleepCtx) mFlags[2] = 0;
      mRst = 1; mLoad = 1; mPc = 0;
    end else if (wdogExpire) begin
      mFlags[3] = 0;
      if (sleepCtx) begin
        mFlags[2] = 0; mLoad = 1; mPc = curPc + 2;
      end else begin
        mRst = 1; mLoad = 1; mPc = 0;
      end
    end else if (resetInstr) begin
      mFlags[4] = 0; mRst = 1; mLoad = 1; mPc = 0;
    end else if (stackFull || stackUnder) begin
      if (stackFull)  mFlags[6] = 1;
      if (stackUnder) mFlags[5] = 1;
      if (stackRstEn) begin mRst = 1; mLoad = 1; mPc = 0; end
    end else if (intWake) begin
      mFlags[2] = 0; mLoad = 1;
      if (intHigh && gieHigh) mPc = 8;
      else if (!intHigh && gieLow) mPc = 24;
      else mPc = curPc + 2;
    end else if (wrEn) begin
      mFlags = wrData;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (flags !== mFlags || rstReq !== mRst || pcLoad !== mLoad || nextPc !== mPc) begin
      errors++;
      $display("FAIL %s: got flags=%b rst=%b load=%b pc=%h, expected flags=%b rst=%b load=%b pc=%h",
               tag, flags, rstReq, pcLoad, nextPc, mFlags, mRst, mLoad, mPc);
    end
  endtask

  task automatic clearIns();
    brownOut = 0; mclr = 0; wdogExpire = 0; resetInstr = 0; stackFull = 0;
    stackUnder = 0; intWake = 0; wrEn = 0; intHigh = 0; gieHigh = 0; gieLow = 0;
    stackRstEn = 0; pwrMode = 2'd0; wrData = '0;
  endtask

  // one clock with inputs as set; then compare and clear
  task automatic step(string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare(tag);
    clearIns();
  endtask

  task automatic writeFlags(logic [6:0] v, string tag);
    wrEn = 1; wrData = v; step(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clearIns();
    curPc = 21'h000100;
    rstN = 0;
    modelPowerOn();
    repeat (2) @(negedge clk);
    compare("R1 power-on state");
    rstN = 1;
    step("R11 idle hold");
    step("R11 idle hold 2");

    writeFlags(7'h7F, "R11 write all ones");
    writeFlags(7'h00, "R11 write zeros");
    writeFlags(7'h7F, "R11 write ones again");

    resetInstr = 1; step("R2 reset instruction");
    step("R9 pulse ends, pc held");

    writeFlags(7'h00, "R11 setup");
    mclr = 1; pwrMode = 2'd0; step("R4 master clear run");
    writeFlags(7'h04, "R11 setup");
    mclr = 1; pwrMode = 2'd1; step("R4 master clear idle");
    writeFlags(7'h04, "R11 setup");
    mclr = 1; pwrMode = 2'd2; step("R4 master clear sleep");

    writeFlags(7'h0C, "R11 setup");
    wdogExpire = 1; pwrMode = 2'd0; step("R5 watchdog run");
    writeFlags(7'h0C, "R11 setup");
    curPc = 21'h000342;
    wdogExpire = 1; pwrMode = 2'd2; step("R6 watchdog sleep");
    writeFlags(7'h0C, "R11 setup");
    curPc = 21'h1FFFFF;
    wdogExpire = 1; pwrMode = 2'd1; step("R6 watchdog idle wrap");
    step("R9 pc held after resume");

    stackFull = 1; stackRstEn = 1; step("R7 overflow with reset");
    writeFlags(7'h00, "R11 setup");
    stackFull = 1; stackRstEn = 0; step("R7 overflow no reset");
    stackUnder = 1; stackRstEn = 0; step("R7 underflow no reset");
    writeFlags(7'h00, "R11 setup");
    stackUnder = 1; stackRstEn = 1; step("R7 underflow with reset");

    curPc = 21'h000200;
    writeFlags(7'h04, "R11 setup");
    intWake = 1; intHigh = 1; gieHigh = 1; step("R8 wake high vector");
    writeFlags(7'h04, "R11 setup");
    intWake = 1; intHigh = 0; gieLow = 1; step("R8 wake low vector");
    writeFlags(7'h04, "R11 setup");
    intWake = 1; intHigh = 1; gieLow = 1; step("R8 wake no enable resumes");
    writeFlags(7'h04, "R11 setup");
    intWake = 1; intHigh = 0; gieHigh = 1; step("R8 wake low with high enable only");

    writeFlags(7'h02, "R11 setup");
    brownOut = 1; step("R3 brown-out keeps power-on flag");
    writeFlags(7'h00, "R11 setup");
    brownOut = 1; step("R3 brown-out power-on flag clear");

    writeFlags(7'h00, "R11 setup");
    brownOut = 1; mclr = 1; wdogExpire = 1; step("R10 brown-out wins");
    writeFlags(7'h1C, "R11 setup");
    wdogExpire = 1; resetInstr = 1; pwrMode = 2'd2; step("R10 watchdog over instruction");
    writeFlags(7'h1C, "R11 setup");
    stackUnder = 1; intWake = 1; step("R10 stack over wake");
    writeFlags(7'h1C, "R11 setup");
    intWake = 1; wrEn = 1; wrData = 7'h40; step("R10 write ignored during wake");
    step("R11 idle hold after events");

    @(negedge clk);
    rstN = 0;
    modelPowerOn();
    #1;
    compare("R1 power-on mid-run");
    @(negedge clk);
    rstN = 1;
    step("R1 after release");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule